// File: doc/BRIEF.md
# Half-Sine Chip Shaper with Quadrature Offset

This block turns a stream of binary chip pairs into signed baseband samples for a pair of digital-to-analog converters. Each chip is drawn as one half-period of a sine wave that spans eight sample clocks. A chip of 1 makes a positive arch and a chip of 0 makes a negative arch. The quadrature branch is held back by half a chip, four sample clocks, relative to the in-phase branch. That lag gives the staggered transitions of offset-QPSK and keeps the envelope near constant.

The block runs on the sample clock. A source strobes `chip_stb` once per chip, normally every eighth cycle, with both chip bits valid in that cycle. The arch magnitudes come from an eight-entry table of sin(pi*(k+0.5)/8) scaled to 2047. Every sample is therefore symmetric about zero and never reaches the most negative 12-bit code. A strobe in the middle of an arch restarts the sequence at once. A strobe that does not arrive lets the output fall back to silence.

Top module: `hs_oqpsk_shaper`

## Requirements
- R1: While `rst` is high, and after it falls while no chip has been strobed, `smp_stb` is 0 and `smp_i` and `smp_q` are 0.
- R2: After a strobe with `chip_i`=1, `smp_i` takes the values +399, +1137, +1702, +2008, +2008, +1702, +1137, +399 on the eight cycles that follow the strobe edge, with `smp_stb` high throughout.
- R3: After a strobe with `chip_i`=0, `smp_i` takes the negated sequence -399, -1137, -1702, -2008, -2008, -1702, -1137, -399.
- R4: When no new strobe arrives after the eighth sample of a chip, `smp_i` returns to 0. `smp_stb` falls once the quadrature tail has also ended, and while `smp_stb` is low both outputs are 0.
- R5: Strobes every eighth cycle produce an unbroken train of arches, with no gap or repeated sample between consecutive chips.
- R6: `smp_q` equals the half-sine value that the quadrature chip bit would give on the in-phase timing, delayed by exactly four cycles. A `chip_q` of 1 is positive and 0 is negative, using the same magnitudes as R2.
- R7: `smp_q` is 0 for the first four cycles of any burst that starts from silence, including the first burst after reset.
- R8: A strobe that arrives before the current arch is complete discards the rest of that arch. The next sample is the first sample of the new chip.
- R9: No sample on either output equals -2048. Every value is symmetric in range about zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one output sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| chip_stb | input | 1 | Marks the cycle that carries a new chip pair |
| chip_i | input | 1 | In-phase chip bit, sampled with `chip_stb` |
| chip_q | input | 1 | Quadrature chip bit, sampled with `chip_stb` |
| smp_stb | output | 1 | High while either branch carries a live sample |
| smp_i | output | 12 | Signed two's complement in-phase sample |
| smp_q | output | 12 | Signed two's complement quadrature sample, lagging by half a chip |

## Verification
The assertions take for granted that `chip_i` and `chip_q` carry known values in every cycle where `chip_stb` is high. They assume nothing about the spacing of strobes: the sign checks, the silence rule and the quadrature start rule hold for any strobe pattern. The stimulus changes inputs only on the falling clock edge and never leaves a chip bit undefined. It mixes regular strobes every eighth cycle with isolated chips, long idle gaps and a strobe four cycles into an arch, so that both the restart path and the fall back to silence are exercised.

// File: rtl/hs_shaper_pkg.sv
package hs_shaper_pkg;

    localparam int SMP_W = 12;
    localparam int SPC   = 8;
    localparam int PH_W  = $clog2(SPC);
    localparam int HALF  = SPC / 2;

    typedef logic signed [SMP_W-1:0] sample_t;
    typedef logic [PH_W-1:0]         phase_t;

    localparam phase_t  PH_LAST = phase_t'(SPC - 1);
    localparam sample_t SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};

    typedef struct packed {
        logic   live;
        logic   load;
        phase_t phase;
    } slot_t;

    // Magnitude of the arch at phase k, mirrored about the chip centre.
    function automatic sample_t hs_mag(phase_t k);
        phase_t m;
        m = (k < phase_t'(HALF)) ? k : PH_LAST - k;
        case (m)
            phase_t'(0): return sample_t'(399);
            phase_t'(1): return sample_t'(1137);
            phase_t'(2): return sample_t'(1702);
            default:     return sample_t'(2008);
        endcase
    endfunction

    function automatic sample_t hs_apply(logic chip, logic live, phase_t k);
        sample_t mag;
        mag = hs_mag(k);
        if (!live)
            return '0;
        return chip ? mag : -mag;
    endfunction

endpackage

// File: rtl/hs_chip_seq.sv
module hs_chip_seq
    import hs_shaper_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  chip_stb,
    output slot_t slot
);
    logic   busy_q;
    phase_t ph_q;

    always_comb begin
        slot.load  = chip_stb;
        slot.live  = chip_stb | busy_q;
        slot.phase = chip_stb ? '0 : ph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
        end else if (slot.live) begin
            ph_q   <= slot.phase + 1'b1;
            busy_q <= (slot.phase != PH_LAST);
        end
    end

    // A running arch never sits on phase zero between strobes.
    assert_busy_phase_R5: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (ph_q != '0));

endmodule

// File: rtl/hs_branch.sv
module hs_branch
    import hs_shaper_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  slot_t   slot,
    input  logic    chip_bit,
    output sample_t shaped
);
    logic held_q;
    logic bit_now;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= 1'b0;
        else if (slot.load)
            held_q <= chip_bit;
    end

    assign bit_now = slot.load ? chip_bit : held_q;
    assign shaped  = hs_apply(bit_now, slot.live, slot.phase);

endmodule

// File: rtl/hs_delay.sv
module hs_delay #(
    parameter int W     = 13,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_stage
        if (j == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[j] <= '0;
                else     stg[j] <= d;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) stg[j] <= '0;
                else     stg[j] <= stg[j-1];
            end
        end
    end

    assign q = stg[DEPTH-1];

endmodule

// File: rtl/hs_oqpsk_shaper.sv
module hs_oqpsk_shaper
    import hs_shaper_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    chip_stb,
    input  logic                    chip_i,
    input  logic                    chip_q,
    output logic                    smp_stb,
    output logic signed [SMP_W-1:0] smp_i,
    output logic signed [SMP_W-1:0] smp_q
);
    slot_t      slot;
    logic [1:0] chip_bits;
    logic [SMP_W:0] lane_out [2];

    assign chip_bits = {chip_q, chip_i};

    hs_chip_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .chip_stb (chip_stb),
        .slot     (slot)
    );

    // Lane 0 is in-phase (one register), lane 1 is quadrature (half chip more).
    for (genvar b = 0; b < 2; b++) begin : g_lane
        localparam int DEP = (b == 0) ? 1 : HALF + 1;
        sample_t shaped;

        hs_branch u_br (
            .clk      (clk),
            .rst      (rst),
            .slot     (slot),
            .chip_bit (chip_bits[b]),
            .shaped   (shaped)
        );

        hs_delay #(.W(SMP_W + 1), .DEPTH(DEP)) u_dl (
            .clk (clk),
            .rst (rst),
            .d   ({slot.live, shaped}),
            .q   (lane_out[b])
        );
    end

    assign smp_i   = lane_out[0][SMP_W-1:0];
    assign smp_q   = lane_out[1][SMP_W-1:0];
    assign smp_stb = lane_out[0][SMP_W] | lane_out[1][SMP_W];

    assert_pos_arch_R2: assert property (@(posedge clk) disable iff (rst)
        (chip_stb && chip_i) |=> (smp_stb && smp_i > 0));

    assert_neg_arch_R3: assert property (@(posedge clk) disable iff (rst)
        (chip_stb && !chip_i) |=> (smp_stb && smp_i < 0));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |-> (smp_i == '0 && smp_q == '0));

    assert_q_lag_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(smp_stb) |-> (smp_q == '0));

    assert_sym_range_R9: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> (smp_i != SMP_MIN && smp_q != SMP_MIN));

endmodule

// File: tb/sim_hs_oqpsk_shaper.sv
module sim_hs_oqpsk_shaper;
    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 20000;
    localparam real PI         = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_stb = 1'b0, chip_i = 1'b0, chip_q = 1'b0;
    logic smp_stb;
    logic signed [11:0] smp_i, smp_q;

    int errors = 0;
    int checks = 0;

    typedef struct packed {
        logic stb;
        logic signed [11:0] i;
        logic signed [11:0] q;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    int m_ph = 0;
    bit m_busy = 0, m_bi = 0, m_bq = 0;
    int qhist [5] = '{default: 0};
    bit ehist [5] = '{default: 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_oqpsk_shaper u0 (
        .clk (clk), .rst (rst),
        .chip_stb (chip_stb), .chip_i (chip_i), .chip_q (chip_q),
        .smp_stb (smp_stb), .smp_i (smp_i), .smp_q (smp_q)
    );

    function automatic int mag(int k);
        return $rtoi(2047.0 * $sin(PI * (real'(k) + 0.5) / 8.0) + 0.5);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver: applies one cycle of input and queues what must follow the next edge.
    task automatic step(bit s, bit ci, bit cq, string tag);
        bit   e;
        int   ph, iv, qv;
        exp_t x;
        @(negedge clk);
        chip_stb = s; chip_i = ci; chip_q = cq;
        if (s) begin
            ph = 0; m_bi = ci; m_bq = cq; e = 1;
        end else if (m_busy) begin
            ph = m_ph; e = 1;
        end else begin
            ph = 0; e = 0;
        end
        iv = e ? (m_bi ? mag(ph) : -mag(ph)) : 0;
        qv = e ? (m_bq ? mag(ph) : -mag(ph)) : 0;
        if (e) begin
            m_busy = (ph < 7);
            m_ph   = ph + 1;
        end
        for (int j = 4; j > 0; j--) begin
            qhist[j] = qhist[j-1];
            ehist[j] = ehist[j-1];
        end
        qhist[0] = qv;
        ehist[0] = e;
        x.stb = e | ehist[4];
        x.i   = 12'(iv);
        x.q   = 12'(qhist[4]);
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, tag);
    endtask

    // Monitor: compares each queued expectation just after its edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  x;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (smp_stb !== x.stb || smp_i !== x.i || smp_q !== x.q) begin
                errors++;
                $display("FAIL %s: actual stb=%0b i=%0d q=%0d expected stb=%0b i=%0d q=%0d",
                         t, smp_stb, smp_i, smp_q, x.stb, x.i, x.q);
            end
            checks++;
            if (smp_i === -12'sd2048 || smp_q === -12'sd2048) begin
                errors++;
                $display("FAIL R9: actual i=%0d q=%0d expected neither -2048", smp_i, smp_q);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=still running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (smp_stb !== 1'b0 || smp_i !== 12'sd0 || smp_q !== 12'sd0) begin
            errors++;
            $display("FAIL R1: actual stb=%0b i=%0d q=%0d expected 0 0 0", smp_stb, smp_i, smp_q);
        end
        @(negedge clk);
        rst = 1'b0;
        idle(3, "R1");

        // Lone positive in-phase chip, negative quadrature chip, then silence.
        step(1, 1, 0, "R2/R7");
        idle(7, "R2/R6");
        idle(10, "R4/R6");

        // Lone negative in-phase chip, positive quadrature chip.
        step(1, 0, 1, "R3/R7");
        idle(7, "R3/R6");
        idle(8, "R4");

        // Regular stream of chips with varied bit pairs.
        for (int c = 0; c < 6; c++) begin
            step(1, c[0], c[1] ^ c[2], "R5");
            idle(7, "R5/R6");
        end
        idle(8, "R4");

        // Strobe four cycles into an arch restarts it.
        step(1, 1, 1, "R8");
        idle(3, "R8");
        step(1, 0, 0, "R8");
        idle(14, "R8/R4");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule